// File: doc/BRIEF.md
# DMA Page Register Bank and Transfer Address Generator

This block keeps two 8-bit page registers for each of four DMA channels: a low page that supplies address bits 23:16 and a high page whose lower seven bits supply bits 30:24. Software reaches both through byte accesses to two small port spaces. Each access carries a 4-bit port offset. The offset does not name a channel directly. It goes through a fixed, sparse lookup, so several offsets select no register.

Alongside the register bank, an address generator builds the full physical address of a transfer. It joins the selected channel's high page, its low page and the channel's current 16-bit address. It then produces the start address of a transfer chunk. In forward mode it adds the transfer position. In reverse (decrementing) mode it subtracts both the position and the length. The result is registered. A system integrator can build the block without the high-page space. In that build, the high-page ports ignore every access and address bits 30:24 are always zero.

Top module: `dma_page_addr`

## Requirements
- R1: The low three bits of the port offset select the channel: 1 selects channel 2, 2 selects channel 3, 3 selects channel 1 and 7 selects channel 0. The values 0, 4, 5 and 6 select nothing.
- R2: In the low-page space (`acc_hp`=0), only offsets 1, 2, 3 and 7 respond. A write to any other offset (0, 4, 5, 6 and 8 to 15) changes no register, and a read of any other offset returns 0.
- R3: In the high-page space (`acc_hp`=1), offsets 1, 2, 3 and 7 respond as in R1. Offset 9 aliases offset 1 (channel 2). Offset 8 and offsets 0, 4, 5, 6 and 10 to 15 are ignored on write and read as 0.
- R4: After reset, every page register and `rd_data` are 0. Read data appears on `rd_data` in the cycle after the read strobe (`acc_en`=1, `acc_we`=0) and holds until the next read strobe.
- R5: The physical address of channel `xfer_ch` is {high page bits 6:0, low page, `cur_addr`}, 31 bits wide. High-page bit 7 never reaches the address.
- R6: With `xfer_dec`=0, the start address is the physical address plus `xfer_pos`, taken modulo 2^31.
- R7: With `xfer_dec`=1, the start address is the physical address minus `xfer_pos` minus `xfer_len`, taken modulo 2^31.
- R8: `start_addr` is registered. It reflects the inputs and page registers of the previous cycle, and it is 0 during reset.
- R9: With `HIGH_PAGE_EN`=0, every high-page write is ignored, every high-page read returns 0, and `start_addr` bits 30:24 carry only the carry out of the lower address arithmetic.
- R10: A channel's low page and high page are separate registers. A write in one space never changes the other space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Port access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_hp | input | 1 | 1 = high-page space, 0 = low-page space |
| acc_off | input | OFF_W (4) | Port offset within the space |
| acc_wdata | input | DATA_W (8) | Write byte |
| rd_data | output | DATA_W (8) | Registered read byte |
| xfer_ch | input | 2 | Channel whose pages form the address |
| cur_addr | input | CADDR_W (16) | Current channel address |
| xfer_pos | input | POS_W (16) | Transfer position |
| xfer_len | input | POS_W (16) | Transfer length |
| xfer_dec | input | 1 | 1 = reverse (decrementing) addressing |
| start_addr | output | HP_BITS+DATA_W+CADDR_W (31) | Registered transfer start address |

## Verification
The bench builds two copies of the block that receive the same stimulus. One keeps the default `HIGH_PAGE_EN`=1, and the other sets it to 0. With both copies, a single sequence of accesses shows that the high-page space responds in one build and is ignored in the other, and that upper address bits are present in one and zero in the other. The default widths make the address 31 bits wide. Reverse transfers from a small physical address therefore wrap around 2^31, so the modulo arithmetic is exercised.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

    localparam int CH_CNT = 4;
    localparam int CH_W   = 2;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } chan_sel_t;

    // Sparse offset-to-channel lookup on the low three offset bits
    function automatic chan_sel_t map_offset(input logic [2:0] lo);
        chan_sel_t s;
        s = '0;
        case (lo)
            3'd1:    begin s.hit = 1'b1; s.ch = 2'd2; end
            3'd2:    begin s.hit = 1'b1; s.ch = 2'd3; end
            3'd3:    begin s.hit = 1'b1; s.ch = 2'd1; end
            3'd7:    begin s.hit = 1'b1; s.ch = 2'd0; end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
    import dma_page_pkg::*;
#(
    parameter int OFF_W        = 4,
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic                    acc_en,
    input  logic                    acc_we,
    input  logic                    acc_hp,
    input  logic [OFF_W-1:0]        acc_off,
    output logic [CH_CNT-1:0]       pg_we,
    output logic [CH_CNT-1:0]       hp_we,
    output logic                    sel_hit,
    output logic [CH_W-1:0]         sel_ch
);

    localparam int LOW_WIN_TOP  = 7;
    localparam int HIGH_WIN_TOP = 9;

    logic      hp_space_ok;
    logic      in_window;
    chan_sel_t lookup;

    generate
        if (HIGH_PAGE_EN) begin : g_hp_on
            assign hp_space_ok = 1'b1;
        end else begin : g_hp_off
            assign hp_space_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        lookup    = map_offset(acc_off[2:0]);
        in_window = acc_hp ? (int'(acc_off) <= HIGH_WIN_TOP)
                           : (int'(acc_off) <= LOW_WIN_TOP);
        sel_hit   = lookup.hit && in_window && (!acc_hp || hp_space_ok);
        sel_ch    = lookup.ch;
        pg_we     = '0;
        hp_we     = '0;
        if (acc_en && acc_we && sel_hit) begin
            if (acc_hp) hp_we[lookup.ch] = 1'b1;
            else        pg_we[lookup.ch] = 1'b1;
        end
    end

    // a_r1_onehot_we: one access strobe touches at most one register
    always_comb begin
        if (acc_en) begin
            a_r1_onehot_we: assert ($onehot0({pg_we, hp_we}));
        end
    end

endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_page_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CH_CNT-1:0]              pg_we,
    input  logic [CH_CNT-1:0]              hp_we,
    input  logic [DATA_W-1:0]              wdata,
    output logic [CH_CNT-1:0][DATA_W-1:0]  pg_all,
    output logic [CH_CNT-1:0][DATA_W-1:0]  hp_all
);

    typedef struct packed {
        logic [CH_CNT-1:0][DATA_W-1:0] pg;
        logic [CH_CNT-1:0][DATA_W-1:0] hp;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < CH_CNT; c++) begin
            if (pg_we[c]) bank_d.pg[c] = wdata;
            if (hp_we[c]) bank_d.hp[c] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign pg_all = bank_q.pg;
    assign hp_all = bank_q.hp;

    // a_r2_pg_discard: low pages move only under a decoded write
    a_r2_pg_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_we == '0) |=> $stable(pg_all));

    // a_r10_hp_isolated: high pages move only under a decoded high write
    a_r10_hp_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_we == '0) |=> $stable(hp_all));

    generate
        if (!HIGH_PAGE_EN) begin : g_hp_off_chk
            // a_r9_hp_zero: without the high space the registers stay clear
            a_r9_hp_zero: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (hp_all == '0));
        end
    endgenerate

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dma_page_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CADDR_W = 16,
    parameter int POS_W   = 16,
    parameter int HP_BITS = 7,
    localparam int PHYS_W = HP_BITS + DATA_W + CADDR_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CH_CNT-1:0][DATA_W-1:0]  pg_all,
    input  logic [CH_CNT-1:0][DATA_W-1:0]  hp_all,
    input  logic [CH_W-1:0]                xfer_ch,
    input  logic [CADDR_W-1:0]             cur_addr,
    input  logic [POS_W-1:0]               xfer_pos,
    input  logic [POS_W-1:0]               xfer_len,
    input  logic                           xfer_dec,
    output logic [PHYS_W-1:0]              start_addr
);

    localparam int EXT_W = PHYS_W - POS_W;

    logic [PHYS_W-1:0] phys;
    logic [PHYS_W-1:0] pos_x;
    logic [PHYS_W-1:0] len_x;
    logic [PHYS_W-1:0] start_d, start_q;
    logic [DATA_W-1:0] hp_sel;

    always_comb begin
        hp_sel  = hp_all[xfer_ch];
        phys    = {hp_sel[HP_BITS-1:0], pg_all[xfer_ch], cur_addr};
        pos_x   = {{EXT_W{1'b0}}, xfer_pos};
        len_x   = {{EXT_W{1'b0}}, xfer_len};
        if (xfer_dec) start_d = phys - pos_x - len_x;
        else          start_d = phys + pos_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= start_d;
    end

    assign start_addr = start_q;

    // a_r6_fwd_base: forward with zero position starts at the channel address
    a_r6_fwd_base: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_dec && xfer_pos == '0) |=> (start_addr[CADDR_W-1:0] == $past(cur_addr)));

    // a_r7_rev_base: reverse with empty window also starts at the channel address
    a_r7_rev_base: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_dec && xfer_pos == '0 && xfer_len == '0)
            |=> (start_addr[CADDR_W-1:0] == $past(cur_addr)));

endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
    import dma_page_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int OFF_W        = 4,
    parameter int CADDR_W      = 16,
    parameter int POS_W        = 16,
    parameter int HP_BITS      = 7,
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 acc_en,
    input  logic                                 acc_we,
    input  logic                                 acc_hp,
    input  logic [OFF_W-1:0]                     acc_off,
    input  logic [DATA_W-1:0]                    acc_wdata,
    output logic [DATA_W-1:0]                    rd_data,
    input  logic [1:0]                           xfer_ch,
    input  logic [CADDR_W-1:0]                   cur_addr,
    input  logic [POS_W-1:0]                     xfer_pos,
    input  logic [POS_W-1:0]                     xfer_len,
    input  logic                                 xfer_dec,
    output logic [HP_BITS+DATA_W+CADDR_W-1:0]    start_addr
);

    logic [CH_CNT-1:0]             pg_we, hp_we;
    logic                          sel_hit;
    logic [CH_W-1:0]               sel_ch;
    logic [CH_CNT-1:0][DATA_W-1:0] pg_all, hp_all;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    dma_page_decode #(
        .OFF_W        (OFF_W),
        .HIGH_PAGE_EN (HIGH_PAGE_EN)
    ) u_decode (
        .acc_en  (acc_en),
        .acc_we  (acc_we),
        .acc_hp  (acc_hp),
        .acc_off (acc_off),
        .pg_we   (pg_we),
        .hp_we   (hp_we),
        .sel_hit (sel_hit),
        .sel_ch  (sel_ch)
    );

    dma_page_bank #(
        .DATA_W       (DATA_W),
        .HIGH_PAGE_EN (HIGH_PAGE_EN)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .pg_we  (pg_we),
        .hp_we  (hp_we),
        .wdata  (acc_wdata),
        .pg_all (pg_all),
        .hp_all (hp_all)
    );

    dma_page_addr_gen #(
        .DATA_W  (DATA_W),
        .CADDR_W (CADDR_W),
        .POS_W   (POS_W),
        .HP_BITS (HP_BITS)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_all     (pg_all),
        .hp_all     (hp_all),
        .xfer_ch    (xfer_ch),
        .cur_addr   (cur_addr),
        .xfer_pos   (xfer_pos),
        .xfer_len   (xfer_len),
        .xfer_dec   (xfer_dec),
        .start_addr (start_addr)
    );

    always_comb begin
        rs_d = rs_q;
        if (acc_en && !acc_we) begin
            if (!sel_hit)    rs_d.rd = '0;
            else if (acc_hp) rs_d.rd = hp_all[sel_ch];
            else             rs_d.rd = pg_all[sel_ch];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_data = rs_q.rd;

    // a_r4_rd_hold: read data changes only after a read strobe
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_we) |=> $stable(rd_data));

    // a_r2_miss_reads_zero: a read that selects no register returns 0
    a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && !sel_hit) |=> (rd_data == '0));

endmodule

// File: tb/dma_page_addr_tb_top.sv
module dma_page_addr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_we = 1'b0, acc_hp = 1'b0;
    logic [3:0]  acc_off = '0;
    logic [7:0]  acc_wdata = '0;
    logic [1:0]  xfer_ch = '0;
    logic [15:0] cur_addr = '0, xfer_pos = '0, xfer_len = '0;
    logic        xfer_dec = 1'b0;
    logic [7:0]  rd_a, rd_b;
    logic [30:0] sa_a, sa_b;

    logic [7:0]  pg_m [4];
    logic [7:0]  hp_m [4];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_page_addr #(.HIGH_PAGE_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_hp(acc_hp), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .rd_data(rd_a), .xfer_ch(xfer_ch), .cur_addr(cur_addr),
        .xfer_pos(xfer_pos), .xfer_len(xfer_len), .xfer_dec(xfer_dec),
        .start_addr(sa_a));

    dma_page_addr #(.HIGH_PAGE_EN(1'b0)) dut_nohp_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_hp(acc_hp), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .rd_data(rd_b), .xfer_ch(xfer_ch), .cur_addr(cur_addr),
        .xfer_pos(xfer_pos), .xfer_len(xfer_len), .xfer_dec(xfer_dec),
        .start_addr(sa_b));

    function automatic int ch_of(input int off, input bit hp);
        if (!hp && off > 7) return -1;
        if (hp && off > 9)  return -1;
        case (off % 8)
            1: return 2;
            2: return 3;
            3: return 1;
            7: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input bit hp, input int off, input logic [7:0] d);
        int c;
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_hp = hp;
        acc_off = 4'(off); acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        c = ch_of(off, hp);
        if (c >= 0) begin
            if (hp) hp_m[c] = d;
            else    pg_m[c] = d;
        end
    endtask

    task automatic check_read(input bit hp, input int off, input string tag);
        int c;
        logic [7:0] ea, eb;
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_hp = hp; acc_off = 4'(off);
        @(negedge clk);
        acc_en = 1'b0;
        c = ch_of(off, hp);
        ea = (c < 0) ? 8'h00 : (hp ? hp_m[c] : pg_m[c]);
        eb = (c < 0 || hp) ? 8'h00 : pg_m[c];
        check($sformatf("%s rd off=%0d hp=%0d", tag, off, hp), 64'(rd_a), 64'(ea));
        check($sformatf("%s rd nohp off=%0d hp=%0d", tag, off, hp), 64'(rd_b), 64'(eb));
    endtask

    task automatic check_addr(input int ch, input logic [15:0] cur, input logic [15:0] pos,
                              input logic [15:0] len, input bit dec, input string tag);
        logic [30:0] pa, pb, ea, eb;
        @(negedge clk);
        xfer_ch = 2'(ch); cur_addr = cur; xfer_pos = pos; xfer_len = len; xfer_dec = dec;
        @(negedge clk);
        pa = {hp_m[ch][6:0], pg_m[ch], cur};
        pb = {7'h00, pg_m[ch], cur};
        if (dec) begin
            ea = pa - 31'(pos) - 31'(len);
            eb = pb - 31'(pos) - 31'(len);
        end else begin
            ea = pa + 31'(pos);
            eb = pb + 31'(pos);
        end
        check({tag, " addr"}, 64'(sa_a), 64'(ea));
        check({tag, " addr nohp"}, 64'(sa_b), 64'(eb));
    endtask

    task automatic t_reset();
        check("R4 R8 reset rd_data", 64'(rd_a), 64'h0);
        check("R8 reset start_addr", 64'(sa_a), 64'h0);
        for (int o = 0; o < 16; o++) check_read(1'b0, o, "R4 reset low");
        for (int o = 0; o < 16; o++) check_read(1'b1, o, "R4 reset high");
    endtask

    task automatic t_low_map();
        do_write(1'b0, 1, 8'h21);
        do_write(1'b0, 2, 8'h32);
        do_write(1'b0, 3, 8'h13);
        do_write(1'b0, 7, 8'h04);
        foreach (pg_m[c]) check_addr(c, 16'h0000, 16'h0, 16'h0, 1'b0, "R1 R5 map");
        check_read(1'b0, 1, "R1 R2");
        check_read(1'b0, 7, "R1 R2");
        for (int o = 0; o < 16; o++) check_read(1'b1, o, "R10 high untouched");
    endtask

    task automatic t_low_invalid();
        int offs [7] = '{0, 4, 5, 6, 8, 9, 15};
        foreach (offs[i]) do_write(1'b0, offs[i], 8'hEE);
        for (int o = 0; o < 16; o++) check_read(1'b0, o, "R2 invalid low");
    endtask

    task automatic t_high_map();
        do_write(1'b1, 1, 8'h52);
        do_write(1'b1, 2, 8'h63);
        do_write(1'b1, 3, 8'h71);
        do_write(1'b1, 7, 8'hFF);
        do_write(1'b1, 9, 8'h2A);
        do_write(1'b1, 8, 8'h99);
        do_write(1'b1, 10, 8'h99);
        do_write(1'b1, 0, 8'h99);
        for (int o = 0; o < 16; o++) check_read(1'b1, o, "R3 R9 high");
        for (int o = 0; o < 16; o++) check_read(1'b0, o, "R10 low untouched");
        check_addr(2, 16'h1234, 16'h0, 16'h0, 1'b0, "R3 alias R5 R9");
        check_addr(0, 16'hABCD, 16'h0, 16'h0, 1'b0, "R5 bit7 R9");
    endtask

    task automatic t_forward();
        check_addr(1, 16'h1000, 16'h0200, 16'h0100, 1'b0, "R6 fwd");
        check_addr(3, 16'hFFF0, 16'h0020, 16'h0000, 1'b0, "R6 fwd carry");
        check_addr(0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, "R6 fwd wrap");
    endtask

    task automatic t_reverse();
        check_addr(1, 16'h1000, 16'h0200, 16'h0100, 1'b1, "R7 rev");
        check_addr(2, 16'h0010, 16'h0020, 16'h0040, 1'b1, "R7 rev borrow");
        do_write(1'b0, 7, 8'h00);
        do_write(1'b1, 7, 8'h00);
        check_addr(0, 16'h0001, 16'h0002, 16'h0003, 1'b1, "R7 rev wrap");
    endtask

    task automatic t_latency();
        @(negedge clk);
        xfer_ch = 2'd3; cur_addr = 16'h0100; xfer_pos = 16'h0; xfer_dec = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cur_addr = 16'h0200;
        @(posedge clk);
        #1;
        check("R8 new value after edge", 64'(sa_a[15:0]), 64'h0200);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_hp = 1'b0; acc_off = 4'd2; acc_wdata = 8'h77;
        @(posedge clk);
        #1;
        acc_en = 1'b0; acc_we = 1'b0;
        pg_m[3] = 8'h77;
        check("R8 old page same edge", 64'(sa_a[23:16]), 64'h32);
        @(posedge clk);
        #1;
        check("R8 new page next edge", 64'(sa_a[23:16]), 64'h77);
    endtask

    task automatic t_rd_hold();
        check_read(1'b0, 2, "R4 hold setup");
        do_write(1'b0, 3, 8'h5C);
        @(negedge clk);
        check("R4 hold after write", 64'(rd_a), 64'h77);
    endtask

    initial begin
        foreach (pg_m[c]) begin pg_m[c] = 8'h00; hp_m[c] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_map();
        t_low_invalid();
        t_high_map();
        t_forward();
        t_reverse();
        t_latency();
        t_rd_hold();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule